// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block walks the translation tables of a reference-style MMU in hardware. When a request is accepted it reads one word from a context table, chosen by a 4-bit context number, and then follows descriptors through up to three table levels in physical memory. At each level the two low bits of the word just read say whether it points to a further table, is the final page entry, or is unusable. When a page entry is reached the block checks the requested access (read, write or execute) against the entry's 3-bit access code for the current privilege mode. It then forms the physical address and reports whether the page may be cached.

After a permitted access the walker writes the entry back with the referenced bit set, and also sets the modified bit for a write. That write is skipped when the entry already carries those bits. The walker reaches memory through a single-word port that has one request line and one acknowledge. A failed walk ends with a fault that gives its kind and the table level where it happened. The block is meant to sit behind a translation cache that calls it on a miss.

Top module: `pt_walker`

## Requirements
- R1: While reset (`rstN` low) is asserted and right after it, `done`, `fault`, `memReq` and `memWe` are 0.
- R2: The entry type is held in bits 1:0 of every table word: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. An invalid or reserved word ends the walk with `fault`=1 and `faultKind`=1, and `faultLevel` gives the level of that word (0 context, 1, 2, 3). The same fault is raised for a page entry at the context level and for a descriptor at level 3.
- R3: The context word is read at `ctxBase` + 4×`reqCtx`. A descriptor gives the next table base as the descriptor with bits 1:0 cleared, shifted left by 4. Inside that table the word at base + 4×index is read. The index comes from VA bits 31:24 at level 1, 23:18 at level 2 and 17:12 at level 3.
- R4: Once `memReq` is raised it stays high, with `memAddr` and `memWe` unchanged, until `memAck` is seen. Each walk issues exactly one read per level it visits.
- R5: A page entry holds the page number in bits 31:8, cacheable in bit 7, modified in bit 6, referenced in bit 5 and the access code in bits 4:2. For a level-3 entry `physAddr` = {entry[31:8], VA[11:0]}, and `cacheable` = entry bit 7.
- R6: A page entry found at level 1 maps a 16 MB region, so `physAddr` = {entry[31:20], VA[23:0]}. One found at level 2 maps 256 KB, so `physAddr` = {entry[31:14], VA[17:0]}.
- R7: `reqKind` is coded 0 read, 1 write, 2 execute, and 3 is treated as read; `reqUser`=1 marks user mode. The access codes grant these rights in user / supervisor mode: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. A request the code does not grant ends with `faultKind`=2 at the level of the entry and writes nothing back.
- R8: A permitted access writes the entry back to the address it was read from (`memWe`=1). The written word has bit 5 set, and bit 6 also set for a write. No write happens when the word would not change.
- R9: `done` is high for exactly one cycle at the end of each walk. `fault`, `faultKind`, `faultLevel`, `physAddr` and `cacheable` stay unchanged after it until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Start a walk (taken only while idle) |
| reqVa | input | 32 | Virtual address to translate |
| reqCtx | input | 4 | Context number |
| ctxBase | input | 36 | Physical byte address of the context table |
| reqKind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqUser | input | 1 | 1 for user mode, 0 for supervisor mode |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 36 | Physical byte address of the word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Memory completes the access this cycle |
| memRdata | input | 32 | Read data, valid with memAck |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk failed |
| faultKind | output | 2 | 1 invalid entry, 2 access denied |
| faultLevel | output | 2 | Level of the failing word: 0 context, 1 to 3 |
| physAddr | output | 36 | Translated physical address (0 on fault) |
| cacheable | output | 1 | Page may be cached (0 on fault) |

## Verification
The referenced-bit update and the modified-bit update are carried in a single write-back word. In the same CHECK cycle the permission decision also determines whether that write takes place at all. The bench provokes this with write requests to entries that have both bits clear, to entries that have only the referenced bit set, and to entries whose code refuses the access. It also sends reads and executes to entries that are already marked. For each walk it judges the outcome from how many writes reached the memory model, the address of the last write and the word written.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int CTX_W  = 4;
  localparam int ENT_W  = 32;
  localparam int PG_OFF = 12;
  localparam int L1_IDX = 8;
  localparam int L2_IDX = 6;
  localparam int L3_IDX = 6;
  // entry bit positions that the walker reads or updates
  localparam int BIT_CACHE = 7;
  localparam int BIT_MOD   = 6;
  localparam int BIT_REF   = 5;
  localparam int ACC_LSB   = 2;
  localparam int PPN_LSB   = 8;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RESERVED = 2'd3
  } entry_type_e;

  typedef enum logic [1:0] {
    ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_EXEC = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0, FK_INVALID = 2'd1, FK_PROT = 2'd2
  } fault_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CTX, S_L1, S_L2, S_L3, S_CHECK, S_WRBACK, S_DONE
  } walk_state_e;

  typedef struct packed {
    logic loadReq;
    logic capture;
    logic descend;
    logic faultInv;
    logic faultProt;
  } ctl_strobe_t;

  // rights granted by an access code, returned as {read, write, exec}
  function automatic logic [2:0] codeRights(input logic [2:0] code, input logic user);
    logic [2:0] r;
    case (code)
      3'd0: r = 3'b100;
      3'd1: r = 3'b110;
      3'd2: r = 3'b101;
      3'd3: r = 3'b111;
      3'd4: r = 3'b001;
      3'd5: r = user ? 3'b100 : 3'b110;
      3'd6: r = user ? 3'b000 : 3'b101;
      default: r = user ? 3'b000 : 3'b111;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memAck,
  input  logic [1:0]  rdType,
  input  logic        permOk,
  input  logic        needWb,
  output ctl_strobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        done
);
  walk_state_e stateQ, stateD;
  logic walking;
  logic ptdOk, pteOk;

  assign walking = (stateQ == S_CTX) || (stateQ == S_L1) ||
                   (stateQ == S_L2)  || (stateQ == S_L3);
  assign ptdOk   = (rdType == ET_PTD) && (stateQ != S_L3);
  assign pteOk   = (rdType == ET_PTE) && (stateQ != S_CTX);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          stateD = S_CTX;
        end
      end
      S_CTX, S_L1, S_L2, S_L3: begin
        if (memAck) begin
          if (ptdOk) begin
            strobe.capture = 1'b1;
            strobe.descend = 1'b1;
            case (stateQ)
              S_CTX:   stateD = S_L1;
              S_L1:    stateD = S_L2;
              default: stateD = S_L3;
            endcase
          end else if (pteOk) begin
            strobe.capture = 1'b1;
            stateD = S_CHECK;
          end else begin
            strobe.faultInv = 1'b1;
            stateD = S_DONE;
          end
        end
      end
      S_CHECK: begin
        if (!permOk) begin
          strobe.faultProt = 1'b1;
          stateD = S_DONE;
        end else if (needWb) begin
          stateD = S_WRBACK;
        end else begin
          stateD = S_DONE;
        end
      end
      S_WRBACK: begin
        if (memAck) stateD = S_DONE;
      end
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq = walking || (stateQ == S_WRBACK);
  assign memWe  = (stateQ == S_WRBACK);
  assign done   = (stateQ == S_DONE);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic [PA_W-1:0]   ctxBase,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic [ENT_W-1:0]  memRdata,
  output logic [1:0]        rdType,
  output logic              permOk,
  output logic              needWb,
  output logic [PA_W-1:0]   addrOut,
  output logic [ENT_W-1:0]  newEntry,
  output logic [PA_W-1:0]   physAddr,
  output logic              cacheable,
  output logic              fault,
  output logic [1:0]        faultKind,
  output logic [1:0]        faultLevel
);
  localparam int IDX_MAX  = L1_IDX;
  localparam int OFS_W    = IDX_MAX + 2;
  localparam int BASE_SH  = 6;           // clear 2 type bits, then shift by 4
  localparam int L1_LSB   = VA_W - L1_IDX;
  localparam int L2_LSB   = L1_LSB - L2_IDX;
  localparam int L3_LSB   = L2_LSB - L3_IDX;

  logic [VA_W-1:0]  vaQ;
  logic [1:0]       kindQ;
  logic             userQ;
  logic [PA_W-1:0]  addrQ;
  logic [ENT_W-1:0] entQ;
  logic [1:0]       levelQ;
  logic             faultQ;
  logic [1:0]       fkQ;
  logic [1:0]       flvQ;

  logic [IDX_MAX-1:0] nextIdx;
  logic [PA_W-1:0]    nextBase;
  logic [PA_W-1:0]    nextAddr;
  logic [PA_W-1:0]    ctxAddr;
  logic [2:0]         rights;
  logic [ENT_W-1:0]   markBits;
  logic [PA_W-1:0]    rawPa;

  // index into the table that the descriptor at levelQ points to
  always_comb begin
    case (levelQ)
      2'd0:    nextIdx = vaQ[VA_W-1:L1_LSB];
      2'd1:    nextIdx = IDX_MAX'(vaQ[L1_LSB-1:L2_LSB]);
      default: nextIdx = IDX_MAX'(vaQ[L2_LSB-1:L3_LSB]);
    endcase
  end

  assign nextBase = {memRdata[ENT_W-1:2], BASE_SH'(0)};
  assign nextAddr = nextBase + PA_W'({nextIdx, 2'b00});
  assign ctxAddr  = ctxBase + PA_W'({reqCtx, 2'b00});
  assign rdType   = memRdata[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ    <= '0;
      kindQ  <= '0;
      userQ  <= 1'b0;
      addrQ  <= '0;
      entQ   <= '0;
      levelQ <= '0;
      faultQ <= 1'b0;
      fkQ    <= FK_NONE;
      flvQ   <= '0;
    end else begin
      if (strobe.loadReq) begin
        vaQ    <= reqVa;
        kindQ  <= reqKind;
        userQ  <= reqUser;
        addrQ  <= ctxAddr;
        levelQ <= '0;
        faultQ <= 1'b0;
        fkQ    <= FK_NONE;
        flvQ   <= '0;
      end
      if (strobe.capture) entQ <= memRdata;
      if (strobe.descend) begin
        addrQ  <= nextAddr;
        levelQ <= levelQ + 2'd1;
      end
      if (strobe.faultInv) begin
        faultQ <= 1'b1;
        fkQ    <= FK_INVALID;
        flvQ   <= levelQ;
      end
      if (strobe.faultProt) begin
        faultQ <= 1'b1;
        fkQ    <= FK_PROT;
        flvQ   <= levelQ;
      end
    end
  end

  // permission against the captured entry
  assign rights = codeRights(entQ[ACC_LSB+2:ACC_LSB], userQ);
  always_comb begin
    case (kindQ)
      ACC_WRITE: permOk = rights[1];
      ACC_EXEC:  permOk = rights[0];
      default:   permOk = rights[2];
    endcase
  end

  // referenced always, modified on a write
  always_comb begin
    markBits = '0;
    markBits[BIT_REF] = 1'b1;
    markBits[BIT_MOD] = (kindQ == ACC_WRITE);
  end
  assign newEntry = entQ | markBits;
  assign needWb   = (newEntry != entQ);

  // page size follows the level the entry was found at
  always_comb begin
    case (levelQ)
      2'd1:    rawPa = {entQ[ENT_W-1:PPN_LSB+12], vaQ[L1_LSB-1:0]};
      2'd2:    rawPa = {entQ[ENT_W-1:PPN_LSB+6],  vaQ[L2_LSB-1:0]};
      default: rawPa = {entQ[ENT_W-1:PPN_LSB],    vaQ[PG_OFF-1:0]};
    endcase
  end

  assign addrOut    = addrQ;
  assign physAddr   = faultQ ? '0 : rawPa;
  assign cacheable  = entQ[BIT_CACHE] & ~faultQ;
  assign fault      = faultQ;
  assign faultKind  = fkQ;
  assign faultLevel = flvQ;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [CTX_W-1:0]  reqCtx,
  input  logic [PA_W-1:0]   ctxBase,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  output logic              memReq,
  output logic              memWe,
  output logic [PA_W-1:0]   memAddr,
  output logic [ENT_W-1:0]  memWdata,
  input  logic              memAck,
  input  logic [ENT_W-1:0]  memRdata,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultKind,
  output logic [1:0]        faultLevel,
  output logic [PA_W-1:0]   physAddr,
  output logic              cacheable
);
  ctl_strobe_t strobe;
  logic [1:0]  rdType;
  logic        permOk;
  logic        needWb;

  ptw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .rdType(rdType), .permOk(permOk), .needWb(needWb),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .done(done)
  );

  ptw_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqVa(reqVa), .reqCtx(reqCtx), .ctxBase(ctxBase),
    .reqKind(reqKind), .reqUser(reqUser), .memRdata(memRdata),
    .rdType(rdType), .permOk(permOk), .needWb(needWb),
    .addrOut(memAddr), .newEntry(memWdata),
    .physAddr(physAddr), .cacheable(cacheable),
    .fault(fault), .faultKind(faultKind), .faultLevel(faultLevel)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [35:0] memAddr,
  input logic [31:0] memWdata,
  input logic        done,
  input logic        fault,
  input logic [1:0]  faultKind,
  input logic [1:0]  faultLevel,
  input logic [35:0] physAddr
);
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(fault) && $stable(physAddr) && $stable(faultKind));

  assert_wb_marks_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memWdata[5] && (memWdata[1:0] == 2'b10));

  assert_fault_kind_R2: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> faultKind != 2'd0);

  assert_prot_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && fault && (faultKind == 2'd2) |-> faultLevel != 2'd0);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memWdata(memWdata), .done(done), .fault(fault),
  .faultKind(faultKind), .faultLevel(faultLevel), .physAddr(physAddr)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [3:0]  reqCtx = '0;
  logic [35:0] ctxBase = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        memReq, memWe, memAck;
  logic [35:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic        done, fault, cacheable;
  logic [1:0]  faultKind, faultLevel;
  logic [35:0] physAddr;

  always #10 clk = ~clk;  // 50 MHz

  pt_walker u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa), .reqCtx(reqCtx),
    .ctxBase(ctxBase), .reqKind(reqKind), .reqUser(reqUser),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .done(done), .fault(fault),
    .faultKind(faultKind), .faultLevel(faultLevel), .physAddr(physAddr),
    .cacheable(cacheable)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem [0:4095];
  int          lat = 0;
  int          waitCnt = 0;
  int          wrCount = 0;
  int          rdCount = 0;
  int          addrMoves = 0;
  logic        pend = 1'b0;
  logic [35:0] heldAddr = '0;
  logic [35:0] lastWa = '0, lastRa = '0, firstRa = '0;
  logic [31:0] lastWd = '0;

  initial begin
    memAck = 1'b0;
    memRdata = '0;
  end

  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
      waitCnt = 0;
      pend = 1'b0;
    end else if (memReq) begin
      if (pend && (memAddr != heldAddr)) addrMoves++;
      pend = 1'b1;
      heldAddr = memAddr;
      if (waitCnt >= lat) begin
        memAck = 1'b1;
        if (memWe) begin
          mem[memAddr[13:2]] = memWdata;
          wrCount++;
          lastWa = memAddr;
          lastWd = memWdata;
        end else begin
          memRdata = mem[memAddr[13:2]];
          if (rdCount == 0) firstRa = memAddr;
          rdCount++;
          lastRa = memAddr;
        end
      end else begin
        waitCnt++;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- vectors ----------------
  typedef struct packed {
    logic [3:0]  ctx;
    logic [31:0] va;
    logic [1:0]  kind;
    logic        user;
    logic [1:0]  lat;
    logic        fault;
    logic [1:0]  fk;
    logic [1:0]  flv;
    logic [35:0] pa;
    logic        cach;
    logic        wr;
    logic [35:0] wa;
    logic [31:0] wd;
    logic [2:0]  nrd;
    logic [35:0] lastRd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    // R5 R8 level-3 read, referenced bit set on write-back
    '{4'd0, {8'h00,6'd0,6'd0,12'h123}, 2'd0, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0,
      {24'h000555,12'h123}, 1'b1, 1'b1, 36'h900, 32'h000555A2, 3'd4, 36'h900, 4'd8},
    // R8 already referenced: no write
    '{4'd0, {8'h00,6'd0,6'd0,12'h124}, 2'd0, 1'b0, 2'd1, 1'b0, 2'd0, 2'd0,
      {24'h000555,12'h124}, 1'b1, 1'b0, 36'h0, 32'h0, 3'd4, 36'h900, 4'd8},
    // R7 code 0 user write denied
    '{4'd0, {8'h00,6'd0,6'd0,12'h456}, 2'd1, 1'b1, 2'd2, 1'b1, 2'd2, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h900, 4'd7},
    // R7 code 5 user write denied
    '{4'd0, {8'h00,6'd0,6'd1,12'h007}, 2'd1, 1'b1, 2'd0, 1'b1, 2'd2, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h904, 4'd7},
    // R8 code 5 supervisor write: referenced and modified together
    '{4'd0, {8'h00,6'd0,6'd1,12'h008}, 2'd1, 1'b0, 2'd3, 1'b0, 2'd0, 2'd0,
      {24'h000777,12'h008}, 1'b1, 1'b1, 36'h904, 32'h000777F6, 3'd4, 36'h904, 4'd8},
    // R7 code 6 user read denied
    '{4'd0, {8'h00,6'd0,6'd2,12'h000}, 2'd0, 1'b1, 2'd0, 1'b1, 2'd2, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h908, 4'd7},
    // R7 code 6 supervisor execute allowed, not cacheable
    '{4'd0, {8'h00,6'd0,6'd2,12'h010}, 2'd2, 1'b0, 2'd1, 1'b0, 2'd0, 2'd0,
      {24'h000888,12'h010}, 1'b0, 1'b1, 36'h908, 32'h0008883A, 3'd4, 36'h908, 4'd7},
    // R7 code 7 supervisor write allowed
    '{4'd0, {8'h00,6'd0,6'd3,12'h020}, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0,
      {24'h000999,12'h020}, 1'b0, 1'b1, 36'h90C, 32'h0009997E, 3'd4, 36'h90C, 4'd7},
    // R7 code 4 read denied
    '{4'd0, {8'h00,6'd0,6'd4,12'h030}, 2'd0, 1'b0, 2'd2, 1'b1, 2'd2, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h910, 4'd7},
    // R7 code 4 user execute allowed
    '{4'd0, {8'h00,6'd0,6'd4,12'h031}, 2'd2, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0,
      {24'h000AAA,12'h031}, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h910, 4'd7},
    // R2 descriptor at level 3
    '{4'd0, {8'h00,6'd0,6'd5,12'h000}, 2'd0, 1'b0, 2'd1, 1'b1, 2'd1, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h914, 4'd2},
    // R2 R3 invalid word in second level-3 table
    '{4'd0, {8'h00,6'd3,6'd0,12'h000}, 2'd0, 1'b0, 2'd3, 1'b1, 2'd1, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'hA00, 4'd2},
    // R2 reserved type at level 2
    '{4'd0, {8'h00,6'd2,6'd9,12'h000}, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 2'd2,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd3, 36'h808, 4'd2},
    // R6 256 KB page at level 2
    '{4'd0, {8'h00,6'd1,6'h15,12'hABC}, 2'd0, 1'b0, 2'd1, 1'b0, 2'd0, 2'd0,
      {18'h048D1,6'h15,12'hABC}, 1'b0, 1'b0, 36'h0, 32'h0, 3'd3, 36'h804, 4'd6},
    // R8 write with both bits already set: no write
    '{4'd0, {8'h00,6'd1,6'h01,12'h002}, 2'd1, 1'b0, 2'd2, 1'b0, 2'd0, 2'd0,
      {18'h048D1,6'h01,12'h002}, 1'b0, 1'b0, 36'h0, 32'h0, 3'd3, 36'h804, 4'd8},
    // R6 16 MB page at level 1, user write on code 3
    '{4'd0, {8'h01,6'h2A,6'h3B,12'h05C}, 2'd1, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0,
      {12'hABC,6'h2A,6'h3B,12'h05C}, 1'b1, 1'b1, 36'h404, 32'hABC000EE, 3'd2, 36'h404, 4'd6},
    // R2 invalid at level 1
    '{4'd0, {8'h02,6'd0,6'd0,12'h000}, 2'd0, 1'b0, 2'd1, 1'b1, 2'd1, 2'd1,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd2, 36'h408, 4'd2},
    // R2 R3 invalid context word for context 1
    '{4'd1, {8'h00,6'd0,6'd0,12'h000}, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 2'd0,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd1, 36'h004, 4'd3},
    // R2 reserved context word
    '{4'd2, {8'h00,6'd0,6'd0,12'h000}, 2'd0, 1'b0, 2'd2, 1'b1, 2'd1, 2'd0,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd1, 36'h008, 4'd2},
    // R2 page entry at context level is invalid
    '{4'd3, {8'h00,6'd0,6'd0,12'h000}, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 2'd0,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd1, 36'h00C, 4'd2},
    // R8 16 MB page read after marking: no write
    '{4'd0, {8'h01,6'h00,6'h00,12'h001}, 2'd0, 1'b0, 2'd3, 1'b0, 2'd0, 2'd0,
      {12'hABC,24'h000001}, 1'b1, 1'b0, 36'h0, 32'h0, 3'd2, 36'h404, 4'd8},
    // R7 code 2 user write denied
    '{4'd0, {8'h00,6'd0,6'd6,12'h000}, 2'd1, 1'b1, 2'd0, 1'b1, 2'd2, 2'd3,
      36'h0, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h918, 4'd7},
    // R7 code 2 user execute allowed
    '{4'd0, {8'h00,6'd0,6'd6,12'h0F0}, 2'd2, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0,
      {24'h000BBB,12'h0F0}, 1'b0, 1'b0, 36'h0, 32'h0, 3'd4, 36'h918, 4'd7},
    // R7 kind 3 treated as read on code 5 user
    '{4'd0, {8'h00,6'd0,6'd1,12'h3FF}, 2'd3, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0,
      {24'h000777,12'h3FF}, 1'b1, 1'b0, 36'h0, 32'h0, 3'd4, 36'h904, 4'd7},
    // R8 write with referenced set, modified clear: only bit 6 added
    '{4'd0, {8'h00,6'd0,6'd7,12'h777}, 2'd1, 1'b1, 2'd2, 1'b0, 2'd0, 2'd0,
      {24'h000CCC,12'h777}, 1'b1, 1'b1, 36'h91C, 32'h000CCCE6, 3'd4, 36'h91C, 4'd8}
  };

  task automatic runWalk(input logic [3:0] c, input logic [31:0] v,
                         input logic [1:0] k, input logic u, output bit ok);
    @(negedge clk);
    reqCtx = c; reqVa = v; reqKind = k; reqUser = u; reqValid = 1'b1;
    rdCount = 0;
    @(negedge clk);
    reqValid = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    bit ok;
    int wrBefore;
    string rq;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    // context table at 0x000
    mem[12'h000] = 32'h00000041;   // ctx0 -> level-1 table at 0x400
    mem[12'h001] = 32'h00000000;   // ctx1 invalid
    mem[12'h002] = 32'h00000003;   // ctx2 reserved
    mem[12'h003] = 32'h00000002;   // ctx3 page entry (not allowed here)
    mem[12'h031] = 32'h00000041;   // second context table at 0x0C0, ctx1 entry
    // level-1 table at 0x400
    mem[12'h100] = 32'h00000081;   // -> level-2 at 0x800
    mem[12'h101] = 32'hABC0008E;   // 16 MB page, code 3, cacheable
    mem[12'h102] = 32'h00000000;
    // level-2 table at 0x800
    mem[12'h200] = 32'h00000091;   // -> level-3 at 0x900
    mem[12'h201] = 32'h12344066;   // 256 KB page, code 1, R and M set
    mem[12'h202] = 32'h00000003;
    mem[12'h203] = 32'h000000A1;   // -> level-3 at 0xA00
    // level-3 table at 0x900
    mem[12'h240] = 32'h00055582;   // code 0
    mem[12'h241] = 32'h00077796;   // code 5
    mem[12'h242] = 32'h0008881A;   // code 6
    mem[12'h243] = 32'h0009991E;   // code 7
    mem[12'h244] = 32'h000AAA32;   // code 4, R set
    mem[12'h245] = 32'h00000091;   // descriptor at level 3
    mem[12'h246] = 32'h000BBB2A;   // code 2, R set
    mem[12'h247] = 32'h000CCCA6;   // code 1, R set
    mem[12'h280] = 32'h00000000;   // table at 0xA00, invalid

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "done in reset", 64'(done), 64'd0);
    chk("R1", "memReq in reset", 64'(memReq), 64'd0);
    chk("R1", "fault in reset", 64'(fault), 64'd0);
    chk("R1", "memWe in reset", 64'(memWe), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "memReq after reset", 64'(memReq), 64'd0);

    for (int n = 0; n < NV; n++) begin
      lat = int'(VEC[n].lat);
      wrBefore = wrCount;
      rq = $sformatf("R%0d vec%0d", VEC[n].req, n);
      runWalk(VEC[n].ctx, VEC[n].va, VEC[n].kind, VEC[n].user, ok);
      chk(rq, "walk completes", 64'(ok), 64'd1);
      chk(rq, "fault", 64'(fault), 64'(VEC[n].fault));
      if (VEC[n].fault) begin
        chk(rq, "fault kind", 64'(faultKind), 64'(VEC[n].fk));
        chk(rq, "fault level", 64'(faultLevel), 64'(VEC[n].flv));
      end else begin
        chk(rq, "physAddr", 64'(physAddr), 64'(VEC[n].pa));
        chk(rq, "cacheable", 64'(cacheable), 64'(VEC[n].cach));
      end
      chk(rq, "write count", 64'(wrCount - wrBefore), 64'(VEC[n].wr));
      if (VEC[n].wr) begin
        chk(rq, "write address", 64'(lastWa), 64'(VEC[n].wa));
        chk(rq, "write data", 64'(lastWd), 64'(VEC[n].wd));
      end
      chk(rq, "reads issued (R4)", 64'(rdCount), 64'(VEC[n].nrd));
      chk(rq, "last read address (R3)", 64'(lastRa), 64'(VEC[n].lastRd));
    end

    // R9 done lasts one cycle and results stay put
    lat = 1;
    runWalk(4'd0, {8'h00,6'd0,6'd1,12'h0AB}, 2'd0, 1'b0, ok);
    chk("R9", "walk completes", 64'(ok), 64'd1);
    @(negedge clk);
    chk("R9", "done low next cycle", 64'(done), 64'd0);
    chk("R9", "physAddr held", 64'(physAddr), 64'({24'h000777,12'h0AB}));
    repeat (3) @(negedge clk);
    chk("R9", "physAddr still held", 64'(physAddr), 64'({24'h000777,12'h0AB}));

    // R9 fault held after done
    runWalk(4'd1, 32'h0, 2'd0, 1'b0, ok);
    @(negedge clk);
    chk("R9", "fault held", 64'({fault, faultKind, faultLevel}), 64'({1'b1, 2'd1, 2'd0}));

    // R3 context word address uses the base plus four times the context
    ctxBase = 36'h0C0;
    lat = 0;
    runWalk(4'd1, {8'h00,6'd0,6'd0,12'h5A5}, 2'd0, 1'b0, ok);
    chk("R3", "first read at ctxBase+4*ctx", 64'(firstRa), 64'h0C4);
    chk("R3", "physAddr through second context table", 64'(physAddr),
        64'({24'h000555,12'h5A5}));
    ctxBase = 36'h0;

    // R4 address stable while waiting for acknowledge
    chk("R4", "address moves while waiting", 64'(addrMoves), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule